// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a pixel raster. A pixel counter runs across each line and a line counter runs down each frame. From these two counters and six programmable timing pairs it derives horizontal sync, vertical sync, a blanking flag and an active-video flag, and it also presents the current pixel position. One timing pair describes a span on one axis: the active width and the total, the blanking interval, or the sync pulse. Each pair sits in one 32-bit register, with the first point minus one in bits 15:0 and the second point minus one in bits 31:16.

Software programs the block through a plain write port made of a write strobe, a 3-bit word address and 32-bit data. It has no read path. Every register other than the key register is protected. A write to any of them is accepted only after the 16-bit key 0x4758 has been written to the key register. Timing writes first land in a staged copy. The working copy that drives the counters takes them over at the end of a frame, or on the next clock when the immediate-update bit is set or the generator is stopped. The control register holds the run bit, the immediate-update bit, the two sync polarities and a power-save mode. The power-save mode can remove either sync pulse and the video independently.

All outputs are plain level signals updated on every clock. There is no handshake: the display path samples them every pixel, and no back-pressure exists.

Top module: `vtg_top`

## Requirements
- R1: After reset the block is locked and stopped, and every staged and working timing value and every control field is zero. With the polarity bits at zero, hsync and vsync are 1, blank and active are 0, and pix_x and pix_y are 0.
- R2: A write to address 0 unlocks the block when wdata[15:0] equals 0x4758 and locks it for any other value. While the block is locked, a write to addresses 1 to 7 changes nothing.
- R3: Address 1 holds the horizontal active width and total, address 2 the horizontal blank start and end, and address 3 the horizontal sync start and end. Addresses 4, 5 and 6 hold the same three pairs for the vertical axis. In each pair, bits 15:0 hold the first value minus one and bits 31:16 hold the second value minus one.
- R4: While the generator runs, pix_x counts up by one per clock. In the clock where pix_x is at or above the horizontal total field, pix_x returns to 0 and pix_y advances. pix_y returns to 0 when it wraps in the same way at the vertical total field.
- R5: active is 1 only while pix_x is at or below the horizontal active field, pix_y is at or below the vertical active field, and video is enabled.
- R6: blank is 1 when either counter is above its blank-start field and at or below its blank-end field, or when video is disabled.
- R7: A sync pulse is present while its counter is above its sync-start field and at or below its sync-end field. The pulse is driven at the level of the polarity bit, and the output rests at the inverse level otherwise.
- R8: Control bits 6:4 select the power-save mode: 0 keeps both syncs and video, 1 keeps both syncs and removes video, 2 removes vsync and video, 3 removes hsync and video, and 4 to 7 remove both syncs and video. A removed sync rests at its inactive level. Removed video forces blank to 1 and active to 0.
- R9: Control bit 0 is the run bit. While it is 0, both counters are held at 0, pix_x and pix_y read 0, blank and active are 0, and both syncs rest at their inactive levels.
- R10: With immediate update off (control bit 1 = 0) and the generator running, staged timing values are copied to the working set only at the clock where both counters wrap together. A timing write that lands on that same clock takes effect one frame later.
- R11: With immediate update on, or with the generator stopped, the working set takes the staged values on every clock, so a timing write is in effect from the second clock after it is written.
- R12: Control bit 2 is the hsync polarity and control bit 3 is the vsync polarity; a value of 1 makes the pulse active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity set by control bit 2 |
| vsync | output | 1 | Vertical sync, polarity set by control bit 3 |
| blank | output | 1 | Blanking interval or video removed |
| active | output | 1 | Visible pixel region |
| pix_x | output | 16 | Current pixel position in the line |
| pix_y | output | 16 | Current line position in the frame |

## Verification
Two functions can fall in the same cycle: a register write that reaches the staged timing copy, and the end-of-frame copy from staged to working. The bench uses its own reference state to find the clock just before the counters wrap together, and it drives a new horizontal total on exactly that edge. The next frame must still use the old line length and the following frame the new one, so the bench checks the line position on a boundary that tells the two apart. Stopping the run bit also collides with counting, because the counter still advances on the same edge. That case is judged by pix_x, blank and the syncs reading their stopped values from the very next sample.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned CW    = 16;   // counter and timing field width
  localparam int unsigned DW    = 32;   // register data width
  localparam int unsigned AW    = 3;    // register address width
  localparam int unsigned KW    = 16;   // key width
  localparam int unsigned NPAIR = 6;    // timing pair registers
  localparam int unsigned NAXIS = 2;
  localparam int unsigned PER_AXIS = NPAIR / NAXIS;

  localparam logic [KW-1:0] UNLOCK_KEY = 16'h4758;
  localparam logic [AW-1:0] A_KEY = 3'd0;
  localparam logic [AW-1:0] A_CTL = 3'd7;

  localparam logic [2:0] PM_ON     = 3'd0;
  localparam logic [2:0] PM_BLANK  = 3'd1;
  localparam logic [2:0] PM_NO_V   = 3'd2;
  localparam logic [2:0] PM_NO_H   = 3'd3;

  typedef logic [CW-1:0] cnt_t;

  typedef struct packed {
    cnt_t act;
    cnt_t tot;
    cnt_t bs;
    cnt_t be;
    cnt_t ss;
    cnt_t se;
  } axis_cfg_t;

  // bit 0 run, bit 1 immediate update, bit 2 hpol, bit 3 vpol, bits 6:4 mode
  typedef struct packed {
    logic [2:0] pmode;
    logic       vpol;
    logic       hpol;
    logic       imm;
    logic       run;
  } ctl_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          frame_wrap,
  output ctl_t          ctl,
  output logic          unlocked,
  output axis_cfg_t     cfg [NAXIS]
);
  logic [DW-1:0] stg_q [NPAIR];
  logic [DW-1:0] wrk_q [NPAIR];
  logic          load;

  // working set follows staged set while stopped, in immediate mode, or at frame end
  assign load = !ctl.run || ctl.imm || frame_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      ctl      <= '0;
      for (int i = 0; i < NPAIR; i++) begin
        stg_q[i] <= '0;
        wrk_q[i] <= '0;
      end
    end else begin
      if (we && addr == A_KEY)
        unlocked <= (wdata[KW-1:0] == UNLOCK_KEY);
      if (we && unlocked && addr == A_CTL)
        ctl <= ctl_t'(wdata[$bits(ctl_t)-1:0]);
      for (int i = 0; i < NPAIR; i++) begin
        if (we && unlocked && addr == AW'(i + 1))
          stg_q[i] <= wdata;
        if (load)
          wrk_q[i] <= stg_q[i];
      end
    end
  end

  for (genvar a = 0; a < NAXIS; a++) begin : g_axis_map
    localparam int unsigned B = a * PER_AXIS;
    assign cfg[a] = '{
      act: wrk_q[B][CW-1:0],     tot: wrk_q[B][DW-1:CW],
      bs:  wrk_q[B+1][CW-1:0],   be:  wrk_q[B+1][DW-1:CW],
      ss:  wrk_q[B+2][CW-1:0],   se:  wrk_q[B+2][DW-1:CW]
    };
  end
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      step,
  input  axis_cfg_t cfg,
  output cnt_t      cnt,
  output logic      wrap,
  output logic      in_act,
  output logic      in_blank,
  output logic      in_sync
);
  assign wrap     = step && (cnt >= cfg.tot);
  assign in_act   = (cnt <= cfg.act);
  assign in_blank = (cnt > cfg.bs) && (cnt <= cfg.be);
  assign in_sync  = (cnt > cfg.ss) && (cnt <= cfg.se);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run)
      cnt <= '0;
    else if (step)
      cnt <= wrap ? '0 : cnt + cnt_t'(1);
  end
endmodule

// File: rtl/vtg_out.sv
module vtg_out
  import vtg_pkg::*;
(
  input  ctl_t  ctl,
  input  logic  h_act,
  input  logic  v_act,
  input  logic  h_blk,
  input  logic  v_blk,
  input  logic  h_syn,
  input  logic  v_syn,
  input  cnt_t  h_cnt,
  input  cnt_t  v_cnt,
  output logic  hsync,
  output logic  vsync,
  output logic  blank,
  output logic  active,
  output cnt_t  pix_x,
  output cnt_t  pix_y
);
  logic hs_en, vs_en, vid_en;

  assign hs_en  = (ctl.pmode == PM_ON) || (ctl.pmode == PM_BLANK) || (ctl.pmode == PM_NO_V);
  assign vs_en  = (ctl.pmode == PM_ON) || (ctl.pmode == PM_BLANK) || (ctl.pmode == PM_NO_H);
  assign vid_en = (ctl.pmode == PM_ON);

  always_comb begin
    if (!ctl.run) begin
      hsync  = ~ctl.hpol;
      vsync  = ~ctl.vpol;
      blank  = 1'b0;
      active = 1'b0;
      pix_x  = '0;
      pix_y  = '0;
    end else begin
      hsync  = (h_syn && hs_en) ? ctl.hpol : ~ctl.hpol;
      vsync  = (v_syn && vs_en) ? ctl.vpol : ~ctl.vpol;
      blank  = h_blk || v_blk || !vid_en;
      active = h_act && v_act && vid_en;
      pix_x  = h_cnt;
      pix_y  = v_cnt;
    end
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          hsync,
  output logic          vsync,
  output logic          blank,
  output logic          active,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y
);
  ctl_t      ctl;
  logic      unlocked;
  axis_cfg_t cfg [NAXIS];
  cnt_t      h_cnt, v_cnt;
  logic      h_wrap, v_wrap, frame_wrap;
  logic      h_act, v_act, h_blk, v_blk, h_syn, v_syn;

  assign frame_wrap = h_wrap && v_wrap;

  vtg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .frame_wrap(frame_wrap), .ctl(ctl), .unlocked(unlocked), .cfg(cfg)
  );

  vtg_axis u_h (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .step(1'b1), .cfg(cfg[0]),
    .cnt(h_cnt), .wrap(h_wrap), .in_act(h_act), .in_blank(h_blk), .in_sync(h_syn)
  );

  vtg_axis u_v (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .step(h_wrap), .cfg(cfg[1]),
    .cnt(v_cnt), .wrap(v_wrap), .in_act(v_act), .in_blank(v_blk), .in_sync(v_syn)
  );

  vtg_out u_out (
    .ctl(ctl), .h_act(h_act), .v_act(v_act), .h_blk(h_blk), .v_blk(v_blk),
    .h_syn(h_syn), .v_syn(v_syn), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .hsync(hsync), .vsync(vsync), .blank(blank), .active(active),
    .pix_x(pix_x), .pix_y(pix_y)
  );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
  import vtg_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          unlocked,
  input ctl_t          ctl,
  input cnt_t          h_cnt,
  input axis_cfg_t     h_cfg,
  input axis_cfg_t     v_cfg,
  input logic          frame_wrap,
  input logic          hsync,
  input logic          vsync,
  input logic          blank,
  input logic          active
);
  assert_locked_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && reg_we && reg_addr != A_KEY) |=> $stable(ctl));

  assert_hstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.run && h_cnt < h_cfg.tot) |=> (h_cnt == $past(h_cnt) + cnt_t'(1)));

  assert_hwrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.run && h_cnt >= h_cfg.tot) |=> (h_cnt == '0));

  assert_video_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.run && ctl.pmode != PM_ON) |-> (blank && !active));

  assert_stopped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.run |-> (!blank && !active && hsync == !ctl.hpol && vsync == !ctl.vpol));

  assert_hold_working_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.run && !ctl.imm && !frame_wrap) |=> ($stable(h_cfg) && $stable(v_cfg)));
endmodule

bind vtg_top vtg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .unlocked(unlocked), .ctl(ctl), .h_cnt(h_cnt), .h_cfg(cfg[0]), .v_cfg(cfg[1]),
  .frame_wrap(frame_wrap), .hsync(hsync), .vsync(vsync), .blank(blank), .active(active)
);

// File: tb/tb_vtg_top.sv
`timescale 1ns/1ps
module tb_vtg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        hsync, vsync, blank, active;
  logic [15:0] pix_x, pix_y;

  vtg_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .hsync(hsync), .vsync(vsync), .blank(blank), .active(active), .pix_x(pix_x), .pix_y(pix_y)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nchecks = 0;
  int nerr = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state: field [k][0] = first value-1, [k][1] = second value-1
  int stg [6][2];
  int wrk [6][2];
  int m_run, m_imm, m_hp, m_vp, m_mode, m_unl;
  int hc, vc;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int in_span(int c, int lo, int hi);
    return (c > lo && c <= hi) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int k = 0; k < 6; k++) begin
        stg[k] = '{0, 0};
        wrk[k] = '{0, 0};
      end
      m_run = 0; m_imm = 0; m_hp = 0; m_vp = 0; m_mode = 0; m_unl = 0;
      hc = 0; vc = 0;
    end else begin
      int nh, nv, fw;
      fw = (m_run != 0 && hc >= wrk[0][1] && vc >= wrk[3][1]) ? 1 : 0;
      nh = hc; nv = vc;
      if (m_run == 0) begin
        nh = 0; nv = 0;
      end else if (hc >= wrk[0][1]) begin
        nh = 0;
        nv = (vc >= wrk[3][1]) ? 0 : vc + 1;
      end else begin
        nh = hc + 1;
      end
      if (m_run == 0 || m_imm != 0 || fw != 0)
        for (int k = 0; k < 6; k++) wrk[k] = stg[k];
      if (reg_we) begin
        if (reg_addr == 3'd0) m_unl = (reg_wdata[15:0] == 16'h4758) ? 1 : 0;
        else if (m_unl != 0) begin
          if (reg_addr == 3'd7) begin
            m_run = reg_wdata[0]; m_imm = reg_wdata[1]; m_hp = reg_wdata[2];
            m_vp = reg_wdata[3]; m_mode = int'(reg_wdata[6:4]);
          end else begin
            stg[reg_addr - 1][0] = int'(reg_wdata[15:0]);
            stg[reg_addr - 1][1] = int'(reg_wdata[31:16]);
          end
        end
      end
      hc = nh; vc = nv;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ehs, evs, ebl, eac, ex, ey, hen, ven, vid;
      hen = (m_mode <= 2) ? 1 : 0;
      ven = (m_mode == 0 || m_mode == 1 || m_mode == 3) ? 1 : 0;
      vid = (m_mode == 0) ? 1 : 0;
      if (m_run == 0) begin
        ehs = 1 - m_hp; evs = 1 - m_vp; ebl = 0; eac = 0; ex = 0; ey = 0;
      end else begin
        ehs = (in_span(hc, wrk[2][0], wrk[2][1]) != 0 && hen != 0) ? m_hp : 1 - m_hp;
        evs = (in_span(vc, wrk[5][0], wrk[5][1]) != 0 && ven != 0) ? m_vp : 1 - m_vp;
        ebl = (in_span(hc, wrk[1][0], wrk[1][1]) != 0 || in_span(vc, wrk[4][0], wrk[4][1]) != 0
               || vid == 0) ? 1 : 0;
        eac = (hc <= wrk[0][0] && vc <= wrk[3][0] && vid != 0) ? 1 : 0;
        ex = hc; ey = vc;
      end
      chk("R4/R9", "pix_x", pix_x, ex);
      chk("R4/R9", "pix_y", pix_y, ey);
      chk("R5/R8", "active", active, eac);
      chk("R6/R8", "blank", blank, ebl);
      chk("R7/R12", "hsync", hsync, ehs);
      chk("R7/R12", "vsync", vsync, evs);
    end
  end

  task automatic wr_now(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  function automatic logic [31:0] ctlw(int run, int imm, int hp, int vp, int mode);
    return 32'(run) | (32'(imm) << 1) | (32'(hp) << 2) | (32'(vp) << 3) | (32'(mode) << 4);
  endfunction

  function automatic logic [31:0] pair(int first, int second);
    return (32'(second - 1) << 16) | 32'(first - 1);
  endfunction

  task automatic program_timings();
    // horizontal: active 6, front 2, sync 3, back 2 -> total 13
    wr(3'd1, pair(6, 13));
    wr(3'd2, pair(6, 13));
    wr(3'd3, pair(8, 11));
    // vertical: active 4, front 1, sync 2, back 1 -> total 8
    wr(3'd4, pair(4, 8));
    wr(3'd5, pair(4, 8));
    wr(3'd6, pair(5, 7));
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1;
      nchecks++; nerr++;
      $display("FAIL watchdog all requirements actual=%0d expected<100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "hsync reset", hsync, 1);
    chk("R1", "vsync reset", vsync, 1);
    chk("R1", "blank reset", blank, 0);
    chk("R1", "pix_x reset", pix_x, 0);

    // R2 locked writes ignored
    wr(3'd7, ctlw(1, 0, 1, 0, 0));
    repeat (5) @(negedge clk);
    chk("R2", "pix_x while locked", pix_x, 0);
    chk("R2", "hsync while locked", hsync, 1);

    wr(3'd0, 32'h0000_4758);
    program_timings();
    wr(3'd7, ctlw(1, 0, 1, 0, 0));
    // R3 line length from packed total field
    repeat (12) @(negedge clk);
    chk("R3", "pix_x at line end", pix_x, 12);
    @(negedge clk);
    chk("R3", "pix_x after wrap", pix_x, 0);
    chk("R3", "pix_y after wrap", pix_y, 1);
    repeat (220) @(negedge clk);

    // R8 power-save modes
    for (int m = 1; m <= 5; m++) begin
      wr(3'd7, ctlw(1, 0, 1, 0, m));
      repeat (110) @(negedge clk);
    end
    wr(3'd7, ctlw(1, 0, 1, 0, 0));

    // R10 write landing on the frame wrap edge
    while (!(hc >= wrk[0][1] && vc >= wrk[3][1])) @(negedge clk);
    wr_now(3'd1, pair(6, 9));
    repeat (12) @(negedge clk);
    chk("R10", "old line length kept", pix_x, 12);
    chk("R10", "still first line", pix_y, 0);
    repeat (200) @(negedge clk);

    // R10 mid-frame staged write waits for frame end
    repeat (17) @(negedge clk);
    wr(3'd1, pair(5, 11));
    repeat (200) @(negedge clk);

    // R11 immediate update
    wr(3'd7, ctlw(1, 1, 0, 1, 0));
    repeat (7) @(negedge clk);
    wr(3'd3, pair(6, 8));
    wr(3'd6, pair(4, 6));
    repeat (150) @(negedge clk);
    wr(3'd1, pair(6, 13));
    repeat (150) @(negedge clk);

    // R9 stop mid-frame
    wr(3'd7, ctlw(0, 0, 1, 1, 0));
    chk("R9", "pix_x stopped", pix_x, 0);
    chk("R9", "hsync stopped", hsync, 0);
    chk("R9", "vsync stopped", vsync, 0);
    chk("R9", "blank stopped", blank, 0);
    // R11 staged write while stopped reaches working set
    wr(3'd1, pair(6, 10));
    repeat (4) @(negedge clk);
    wr(3'd7, ctlw(1, 0, 1, 1, 0));
    repeat (9) @(negedge clk);
    chk("R11", "pix_x at new line end", pix_x, 9);
    @(negedge clk);
    chk("R11", "pix_y after new wrap", pix_y, 1);
    repeat (150) @(negedge clk);

    // R2 relock, then ignored writes
    wr(3'd0, 32'h0000_0000);
    wr(3'd7, ctlw(0, 0, 0, 0, 0));
    wr(3'd1, pair(3, 4));
    repeat (4) @(negedge clk);
    chk("R2", "still running after locked stop", (pix_x != 0 || pix_y != 0 || blank) ? 1 : 0, 1);
    repeat (150) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule